// File: doc/BRIEF.md
# Predicated Wide-Amount Vector Right Shifter

This block performs a logical right shift on every element of a packed vector of fixed length. Elements are 8, 16 or 32 bits wide, as a 2-bit size code selects. Each element does not take its shift count from an element of its own width. It takes it from the unsigned 64-bit doubleword of the second operand that overlaps the element's bit position. The full 64-bit count is significant. Any count equal to or larger than the element width clears the element. A count is never wrapped modulo the width.

A predicate with one bit per byte of the vector decides which elements receive the shifted value. An element is active when the predicate bit at its lowest byte is set. An inactive element passes the first operand through unchanged. Size code 3 has no meaning: the block raises an illegal flag and returns the first operand untouched.

The operation takes one registered stage. A result, its illegal flag and a done pulse appear on the clock edge after the valid strobe. The datapath computes every element of every width on every cycle, so the latency never depends on operand values.

Top module: `vshr_wide`

## Requirements
- R1: During and immediately after synchronous reset, `done`, `illegal` and `result` are all zero.
- R2: `done` is high for exactly the one cycle that follows each cycle with `in_valid` high, and low otherwise, for any data or predicate values.
- R3: With size code 0, each 8-bit element e of `src_a` is shifted right by the saturated amount taken from `src_b`.
- R4: With size code 1, the same operation is applied to 16-bit elements.
- R5: With size code 2, the same operation is applied to 32-bit elements.
- R6: Element e uses the amount in bits [64k+63:64k] of `src_b`, where k = floor(e*esize/64).
- R7: The amount is a full 64-bit unsigned value. Any amount at or above esize, including values whose low bits are small but whose upper bits are nonzero, yields an all-zero element.
- R8: The shift is logical: vacated high bits are filled with zero, even when the element's top bit is 1.
- R9: An element whose predicate is inactive appears in `result` equal to its `src_a` value. An all-zero predicate therefore returns `src_a`.
- R10: Element e is active when `pred[e*esize/8]` is 1. The other predicate bits covering the element have no effect.
- R11: Size code 3 sets `illegal` to 1 and returns `src_a` unchanged in `result`. A legal code clears `illegal`.
- R12: In a cycle with `in_valid` low, `result` and `illegal` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| size_code | input | 2 | Element width: 0 = 8, 1 = 16, 2 = 32, 3 = illegal |
| src_a | input | VLEN | Vector to be shifted |
| src_b | input | VLEN | Vector of 64-bit shift amounts |
| pred | input | VLEN/8 | One predicate bit per byte |
| done | output | 1 | Result valid pulse |
| result | output | VLEN | Shifted vector |
| illegal | output | 1 | Size code 3 was presented |

## Verification
Every result, illegal flag and done pulse is due exactly one rising edge after the cycle in which `in_valid` is high, whatever the operand values. The bench raises `in_valid` at a falling edge and reads all three outputs at the next falling edge, half a period after the capturing edge. It then lowers the strobe and samples again one cycle later. That second sample confirms that `done` has dropped and that the result and flag held their values. The expected vectors come from an arithmetic per-element model in the bench that walks every element at every size code.

// File: rtl/vshr_pkg.sv
package vshr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } size_e;

    localparam int AMT_W = 64;

    typedef struct packed {
        logic done;
        logic illegal;
    } ctl_t;

    function automatic int elem_bits(input size_e s);
        return 8 << int'(s);
    endfunction

endpackage

// File: rtl/vshr_lane.sv
module vshr_lane #(
    parameter int EW = 8
) (
    input  logic [EW-1:0]                 elem,
    input  logic [vshr_pkg::AMT_W-1:0]    amt,
    input  logic                          act,
    output logic [EW-1:0]                 res
);
    localparam int SHW = $clog2(EW);

    logic          sat;
    logic [EW-1:0] shifted;

    always_comb begin
        sat     = (amt >= vshr_pkg::AMT_W'(EW));
        shifted = sat ? '0 : (elem >> amt[SHW-1:0]);
        res     = act ? shifted : elem;
    end
endmodule

// File: rtl/vshr_plane.sv
module vshr_plane #(
    parameter int VLEN = 256,
    parameter int EW   = 8
) (
    input  logic [VLEN-1:0]    src_a,
    input  logic [VLEN-1:0]    src_b,
    input  logic [VLEN/EW-1:0] act,
    output logic [VLEN-1:0]    res
);
    localparam int NE = VLEN / EW;

    for (genvar e = 0; e < NE; e++) begin : g_lane
        localparam int CHUNK = (e * EW) / vshr_pkg::AMT_W;
        vshr_lane #(.EW(EW)) u_lane (
            .elem (src_a[e*EW +: EW]),
            .amt  (src_b[CHUNK*vshr_pkg::AMT_W +: vshr_pkg::AMT_W]),
            .act  (act[e]),
            .res  (res[e*EW +: EW])
        );
    end
endmodule

// File: rtl/vshr_wide.sv
module vshr_wide #(
    parameter int VLEN = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        size_code,
    input  logic [VLEN-1:0]   src_a,
    input  logic [VLEN-1:0]   src_b,
    input  logic [VLEN/8-1:0] pred,
    output logic              done,
    output logic [VLEN-1:0]   result,
    output logic              illegal
);
    import vshr_pkg::*;

    localparam int NB = VLEN / 8;
    localparam int NH = VLEN / 16;
    localparam int NW = VLEN / 32;

    initial begin
        if (VLEN % AMT_W != 0 || VLEN < AMT_W)
            $error("VLEN must be a positive multiple of 64");
    end

    logic [NB-1:0]   act_b;
    logic [NH-1:0]   act_h;
    logic [NW-1:0]   act_w;
    logic [VLEN-1:0] res_b, res_h, res_w, res_sel;
    size_e           sz;
    ctl_t            ctl_d, ctl_q;
    logic [VLEN-1:0] res_q;

    // Activity bit of each element is the predicate bit of its lowest byte
    for (genvar e = 0; e < NB; e++) begin : g_act_b
        assign act_b[e] = pred[e];
    end
    for (genvar e = 0; e < NH; e++) begin : g_act_h
        assign act_h[e] = pred[e*2];
    end
    for (genvar e = 0; e < NW; e++) begin : g_act_w
        assign act_w[e] = pred[e*4];
    end

    vshr_plane #(.VLEN(VLEN), .EW(8))  u_plane_b (
        .src_a(src_a), .src_b(src_b), .act(act_b), .res(res_b));
    vshr_plane #(.VLEN(VLEN), .EW(16)) u_plane_h (
        .src_a(src_a), .src_b(src_b), .act(act_h), .res(res_h));
    vshr_plane #(.VLEN(VLEN), .EW(32)) u_plane_w (
        .src_a(src_a), .src_b(src_b), .act(act_w), .res(res_w));

    always_comb begin
        sz = size_e'(size_code);
        unique case (sz)
            SZ_BYTE: res_sel = res_b;
            SZ_HALF: res_sel = res_h;
            SZ_WORD: res_sel = res_w;
            default: res_sel = src_a;
        endcase
        ctl_d.done    = in_valid;
        ctl_d.illegal = (sz == SZ_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            res_q <= '0;
        end else begin
            ctl_q.done <= ctl_d.done;
            if (in_valid) begin
                ctl_q.illegal <= ctl_d.illegal;
                res_q         <= res_sel;
            end
        end
    end

    assign done    = ctl_q.done;
    assign illegal = ctl_q.illegal;
    assign result  = res_q;
endmodule

// File: rtl/vshr_wide_chk.sv
module vshr_wide_chk #(
    parameter int VLEN = 256
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        size_code,
    input logic [VLEN-1:0]   src_a,
    input logic [VLEN/8-1:0] pred,
    input logic              done,
    input logic [VLEN-1:0]   result,
    input logic              illegal
);
    p_done_follows_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> done);
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !done);
    p_bad_size_passthru_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code == 2'd3) |=> (illegal && result == $past(src_a)));
    p_good_size_flag_r11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && size_code != 2'd3) |=> !illegal);
    p_no_active_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pred == '0) |=> result == $past(src_a));
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && $stable(illegal)));
endmodule

bind vshr_wide vshr_wide_chk #(.VLEN(VLEN)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
    .src_a(src_a), .pred(pred), .done(done), .result(result),
    .illegal(illegal));

// File: tb/vshr_wide_test.sv
module vshr_wide_test;
    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [1:0]      size_code;
    logic [VLEN-1:0] src_a, src_b;
    logic [PW-1:0]   pred;
    logic            done, illegal;
    logic [VLEN-1:0] result;

    int n_vec  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vshr_wide #(.VLEN(VLEN)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .size_code(size_code),
        .src_a(src_a), .src_b(src_b), .pred(pred), .done(done),
        .result(result), .illegal(illegal));

    // Arithmetic model built from the requirements
    function automatic logic [VLEN-1:0] model(input int sz, input logic [VLEN-1:0] a,
                                              input logic [VLEN-1:0] b, input logic [PW-1:0] p);
        logic [VLEN-1:0] r;
        int esz;
        if (sz == 3) return a;
        esz = 8 << sz;
        r = '0;
        for (int e = 0; e < VLEN / esz; e++) begin
            logic [63:0] amt;
            logic [31:0] msk, el, o;
            longint unsigned sh;
            amt = b[((e * esz) / 64) * 64 +: 64];
            msk = (esz == 32) ? 32'hFFFF_FFFF : ((32'd1 << esz) - 32'd1);
            el  = 32'(a >> (e * esz)) & msk;
            sh  = (amt >= 64'(esz)) ? longint'(esz) : amt;
            o   = (sh >= 32) ? 32'd0 : (el >> sh);
            if (!p[(e * esz) / 8]) o = el;
            r = r | (VLEN'(o) << (e * esz));
        end
        return r;
    endfunction

    function automatic logic [63:0] pick_amt(input int esz);
        case ($urandom % 8)
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'(esz - 1);
            3: return 64'(esz);
            4: return 64'(esz + 1);
            5: return {32'h0000_0001, 32'(($urandom % 3))};
            6: return 64'($urandom % esz);
            default: return {$urandom, $urandom};
        endcase
    endfunction

    function automatic logic [VLEN-1:0] rand_vec();
        logic [VLEN-1:0] v;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(input string tag, input logic [VLEN-1:0] act,
                         input logic [VLEN-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input int sz, input logic [VLEN-1:0] a, input logic [VLEN-1:0] b,
                         input logic [PW-1:0] p, input string tag);
        logic [VLEN-1:0] exp;
        exp = model(sz, a, b, p);
        @(negedge clk);
        size_code = 2'(sz);
        src_a = a; src_b = b; pred = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result, exp);
        check("R2 done pulse", VLEN'(done), VLEN'(1));
        check("R11 illegal flag", VLEN'(illegal), VLEN'(sz == 3));
        src_a = rand_vec(); src_b = rand_vec(); pred = PW'(rand_vec());
        size_code = 2'($urandom);
        @(negedge clk);
        check("R2 done drops", VLEN'(done), VLEN'(0));
        check("R12 result held", result, exp);
        check("R12 flag held", VLEN'(illegal), VLEN'(sz == 3));
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [VLEN-1:0] a, b;
        rst = 1'b1; in_valid = 1'b0; size_code = '0;
        src_a = '0; src_b = '0; pred = '0;
        repeat (3) @(negedge clk);
        check("R1 reset result", result, '0);
        check("R1 reset done", VLEN'(done), VLEN'(0));
        check("R1 reset illegal", VLEN'(illegal), VLEN'(0));
        rst = 1'b0;

        // R6: distinct amount per 64-bit chunk, byte elements
        b = '0;
        for (int k = 0; k < VLEN / 64; k++) b[k*64 +: 64] = 64'(k % 8);
        apply(0, {VLEN/8{8'hFF}}, b, '1, "R6 chunk select bytes");
        apply(2, {VLEN/32{32'hFFFF_FFFF}}, b, '1, "R6 chunk select words");

        // R7: upper bits set, low bits zero -> all zero, no wrap
        b = {VLEN/64{64'h0000_0001_0000_0000}};
        apply(0, rand_vec(), b, '1, "R7 saturate bytes");
        apply(1, rand_vec(), {VLEN/64{64'd16}}, '1, "R7 amount equals width");
        check("R7 zero result", result, '0);

        // R8: logical fill with the top bit set
        apply(0, {VLEN/8{8'h80}}, {VLEN/64{64'd1}}, '1, "R8 zero fill");
        check("R8 direct value", result, {VLEN/8{8'h40}});

        // R9: empty predicate
        a = rand_vec();
        apply(1, a, {VLEN/64{64'd3}}, '0, "R9 all inactive");
        check("R9 direct value", result, a);

        // R10: only non-leading predicate bits set -> inactive words
        a = rand_vec();
        apply(2, a, {VLEN/64{64'd4}}, {PW/4{4'hE}}, "R10 extra bits ignored");
        check("R10 direct value", result, a);
        apply(2, a, {VLEN/64{64'd4}}, {PW/4{4'h1}}, "R10 leading bit active");
        apply(1, a, {VLEN/64{64'd4}}, {PW/2{2'h2}}, "R10 half inactive");
        check("R10 half direct value", result, a);

        // R11: illegal size
        a = rand_vec();
        apply(3, a, '0, '1, "R11 passthrough");
        check("R11 direct value", result, a);

        // Sweep of every size code with random data, predicates and amounts
        for (int sz = 0; sz < 4; sz++) begin
            for (int n = 0; n < 150; n++) begin
                int esz;
                string tg;
                esz = 8 << (sz == 3 ? 0 : sz);
                b = '0;
                for (int k = 0; k < VLEN / 64; k++) b[k*64 +: 64] = pick_amt(esz);
                tg = (sz == 0) ? "R3 byte sweep" : (sz == 1) ? "R4 half sweep" :
                     (sz == 2) ? "R5 word sweep" : "R11 illegal sweep";
                apply(sz, rand_vec(), b, PW'(rand_vec()), tg);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule